// File: doc/BRIEF.md
# Next program counter unit

This block keeps the program counter of a processor whose instructions are all 32 bits wide, and picks the address of the following instruction once per clock. Four candidates exist: the plain sequential successor, a conditional PC-relative branch that fires on equality or on inequality of two source registers, an absolute jump that puts a 26-bit word index under the upper bits of the successor address, and a jump that takes a whole 32-bit register value.

The surrounding pipeline presents the instruction fetched at the current PC, together with the two source-register values read for it. The block decodes only the opcode and function bits that steer control flow and ignores every other field. A hold input freezes the PC, and a synchronous reset returns it to its start address.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `pc` to 0 at that edge, and any instruction presented during that cycle has no effect.
- R2: With `hold` high and `rst` low, `pc` keeps its value across the edge, whatever the instruction, including jumps and taken branches.
- R3: An instruction that does not affect control flow moves `pc` to `pc + 4`, wrapping modulo 2^32. This includes opcode 000000 with any function code other than 001000.
- R4: Branch-if-equal (opcode 000100 in bits 31:26), with `rs_val == rt_val`, moves `pc` to `pc + 4 + (sign-extended bits 15:0) * 4`.
- R5: Branch-if-equal with `rs_val != rt_val` moves `pc` to `pc + 4`.
- R6: Branch-if-not-equal (opcode 000101) is taken to the same target as R4 when `rs_val != rt_val`. When they are equal, it moves `pc` to `pc + 4`.
- R7: The 16-bit branch offset is two's complement. 0x8000 gives -32768 words, and 0x7FFF gives +32767 words.
- R8: Jump (opcode 000010) moves `pc` to {bits 31:28 of `pc + 4`, instruction bits 25:0, 2'b00}.
- R9: Jump-and-link (opcode 000011) moves `pc` to the same target as R8.
- R10: Jump-register (opcode 000000, function code 001000 in bits 5:0) moves `pc` to all 32 bits of `rs_val`, with no alignment applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freezes the program counter when high |
| instr | input | 32 | Instruction fetched at the current `pc` |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Registered program counter |

## Verification
The assertions take for granted that `instr`, `rs_val`, `rt_val`, `hold` and `rst` are known and steady around each rising edge. They also assume that the instruction presented belongs to the current `pc`, so an expectation can refer to the sampled `pc` of the previous cycle. The bench changes every input only on the falling edge. It keeps a model PC that starts from reset and moves only as the requirements say. For every vector it builds register values that either match or differ on purpose, so that each branch direction is reached from a known state.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN    = 32;
    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int OFS_W   = 16;
    localparam int IDX_W   = 26;
    localparam int ALIGN_W = 2;
    localparam int HI_W    = XLEN - IDX_W - ALIGN_W;
    localparam int SEXT_W  = XLEN - OFS_W - ALIGN_W;

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JUMP    = 6'b000010;
    localparam logic [OP_W-1:0] OPC_JLINK   = 6'b000011;
    localparam logic [OP_W-1:0] OPC_BR_EQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_BR_NE   = 6'b000101;
    localparam logic [FN_W-1:0] FN_JREG     = 6'b001000;

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    typedef enum logic [1:0] {
        NXT_SEQ  = 2'd0,
        NXT_BR   = 2'd1,
        NXT_ABS  = 2'd2,
        NXT_REG  = 2'd3
    } nxt_src_e;

    typedef struct packed {
        logic              br_eq;
        logic              br_ne;
        logic              jmp_abs;
        logic              jmp_reg;
        logic [OFS_W-1:0]  ofs;
        logic [IDX_W-1:0]  idx;
    } flow_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] br;
        logic [XLEN-1:0] abs;
        logic [XLEN-1:0] reg_t;
    } cand_t;

    function automatic logic [XLEN-1:0] word_ofs(input logic [OFS_W-1:0] o);
        return {{SEXT_W{o[OFS_W-1]}}, o, {ALIGN_W{1'b0}}};
    endfunction

    function automatic logic [XLEN-1:0] splice_abs(input logic [XLEN-1:0] base,
                                                   input logic [IDX_W-1:0] ix);
        return {base[XLEN-1 -: HI_W], ix, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output flow_t           flow
);
    logic [OP_W-1:0] opc;
    logic [FN_W-1:0] fn;

    always_comb begin
        opc          = instr[XLEN-1 -: OP_W];
        fn           = instr[FN_W-1:0];
        flow         = '0;
        flow.ofs     = instr[OFS_W-1:0];
        flow.idx     = instr[IDX_W-1:0];
        unique case (opc)
            OPC_BR_EQ:   flow.br_eq   = 1'b1;
            OPC_BR_NE:   flow.br_ne   = 1'b1;
            OPC_JUMP,
            OPC_JLINK:   flow.jmp_abs = 1'b1;
            OPC_SPECIAL: flow.jmp_reg = (fn == FN_JREG);
            default:     ;
        endcase
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [XLEN-1:0]  pc,
    input  logic [OFS_W-1:0] ofs,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  rs_val,
    output cand_t            cand
);
    logic [XLEN-1:0] succ;

    always_comb begin
        succ       = pc + STEP;
        cand.seq   = succ;
        cand.br    = succ + word_ofs(ofs);
        cand.abs   = splice_abs(succ, idx);
        cand.reg_t = rs_val;
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  flow_t           flow,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  cand_t           cand,
    output nxt_src_e        src,
    output logic [XLEN-1:0] nxt
);
    logic same;
    logic take;

    always_comb begin
        same = (rs_val == rt_val);
        take = (flow.br_eq & same) | (flow.br_ne & ~same);
        if (flow.jmp_reg)      src = NXT_REG;
        else if (flow.jmp_abs) src = NXT_ABS;
        else if (take)         src = NXT_BR;
        else                   src = NXT_SEQ;
        unique case (src)
            NXT_BR:  nxt = cand.br;
            NXT_ABS: nxt = cand.abs;
            NXT_REG: nxt = cand.reg_t;
            default: nxt = cand.seq;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] START_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hold,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] pc
);
    flow_t           flow;
    cand_t           cand;
    nxt_src_e        src;
    logic [XLEN-1:0] nxt;
    logic [XLEN-1:0] pc_q;

    npc_decode u_dec (
        .instr (instr),
        .flow  (flow)
    );

    npc_targets u_tgt (
        .pc     (pc_q),
        .ofs    (flow.ofs),
        .idx    (flow.idx),
        .rs_val (rs_val),
        .cand   (cand)
    );

    npc_select u_sel (
        .flow   (flow),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .cand   (cand),
        .src    (src),
        .nxt    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)        pc_q <= START_PC;
        else if (!hold) pc_q <= nxt;
    end

    assign pc = pc_q;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        hold,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [31:0] pc
);
    logic [5:0] op;
    logic       is_beq, is_j, is_jr, is_plain;

    assign op       = instr[31:26];
    assign is_beq   = (op == 6'b000100);
    assign is_j     = (op == 6'b000010) || (op == 6'b000011);
    assign is_jr    = (op == 6'b000000) && (instr[5:0] == 6'b001000);
    assign is_plain = !is_beq && !is_j && !is_jr && (op != 6'b000101);

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> pc == 32'h0); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(pc)); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!hold && is_plain) |=> pc == $past(pc) + 32'd4); // R3

    AST_BEQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (!hold && is_beq && rs_val != rt_val) |=> pc == $past(pc) + 32'd4); // R5

    AST_ABS_LOW: assert property (@(posedge clk) disable iff (rst)
        (!hold && is_j) |=> pc[27:0] == {$past(instr[25:0]), 2'b00}); // R8

    AST_JREG_FULL: assert property (@(posedge clk) disable iff (rst)
        (!hold && is_jr) |=> pc == $past(rs_val)); // R10
endmodule

bind npc_unit npc_unit_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .hold   (hold),
    .instr  (instr),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .pc     (pc)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [31:0] pc;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;
    logic [31:0] model_pc = 32'h0;

    typedef struct {
        logic [31:0] want;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    npc_unit u_dut (
        .clk(clk), .rst(rst), .hold(hold), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc)
    );

    function automatic logic [31:0] expect_next(logic [31:0] cur, logic [31:0] ins,
                                                logic [31:0] a, logic [31:0] b);
        logic [31:0] s;
        logic [31:0] d;
        s = cur + 32'd4;
        d = 32'(signed'(ins[15:0])) * 32'd4;
        case (ins[31:26])
            6'b000100: return (a == b) ? s + d : s;
            6'b000101: return (a != b) ? s + d : s;
            6'b000010, 6'b000011: return {s[31:28], ins[25:0], 2'b00};
            6'b000000: return (ins[5:0] == 6'b001000) ? a : s;
            default:   return s;
        endcase
    endfunction

    task automatic drive(logic [31:0] ins, logic [31:0] a, logic [31:0] b,
                         logic hl, string tag);
        item_t it;
        @(negedge clk);
        rst = 1'b0; instr = ins; rs_val = a; rt_val = b; hold = hl;
        if (!hl) model_pc = expect_next(model_pc, ins, a, b);
        it.want = model_pc;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic drive_reset(logic [31:0] ins);
        item_t it;
        @(negedge clk);
        rst = 1'b1; instr = ins; hold = 1'b0;
        model_pc = 32'h0;
        it.want = 32'h0;
        it.tag  = "R1";
        sb.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                vectors++;
                if (pc !== it.want) begin
                    misses++;
                    $display("FAIL %s: pc=%h expected=%h", it.tag, pc, it.want);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        if (pc !== 32'h0) begin
            misses++;
            $display("FAIL R1: pc=%h expected=%h", pc, 32'h0);
        end
        drive(32'h0128_4020, 1, 2, 1'b0, "R3");                 // r-type add
        drive(32'h2108_0005, 0, 0, 1'b0, "R3");                 // immediate op
        drive(32'h0000_0009, 7, 0, 1'b0, "R3");                 // special, fn 001001
        drive({6'b000100, 10'h0, 16'd3}, 5, 5, 1'b0, "R4");     // equal, +3 words
        drive({6'b000100, 10'h0, 16'd3}, 5, 6, 1'b0, "R5");
        drive({6'b000101, 10'h0, 16'hFFFE}, 1, 9, 1'b0, "R6");  // taken, -2 words
        drive({6'b000101, 10'h0, 16'd8}, 4, 4, 1'b0, "R6");     // not taken
        drive({6'b000010, 26'h000_0040}, 0, 0, 1'b1, "R2");     // held jump
        drive({6'b000100, 10'h0, 16'd9}, 3, 3, 1'b1, "R2");     // held branch
        drive({6'b000010, 26'h000_0040}, 0, 0, 1'b0, "R8");
        drive({6'b000011, 26'h3FF_FFFF}, 0, 0, 1'b0, "R9");
        drive(32'h03E0_0008, 32'hA000_0101, 0, 1'b0, "R10");    // unaligned value
        drive({6'b000010, 26'h012_3456}, 0, 0, 1'b0, "R8");     // keeps upper 4 bits
        drive(32'h03E0_0008, 32'h0010_0000, 0, 1'b0, "R10");
        drive({6'b000100, 10'h0, 16'h7FFF}, 2, 2, 1'b0, "R7");
        drive({6'b000101, 10'h0, 16'h8000}, 2, 3, 1'b0, "R7");
        drive(32'h03E0_0008, 32'hFFFF_FFFC, 0, 1'b0, "R10");
        drive(32'h0000_0000, 0, 0, 1'b0, "R3");                 // wraps to 0
        drive(32'h0128_4020, 0, 0, 1'b0, "R3");
        drive_reset({6'b000010, 26'h155_5555});
        drive({6'b000100, 10'h0, 16'd1}, 0, 0, 1'b0, "R4");
        drive(32'h0128_4020, 0, 0, 1'b0, "R3");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule